// File: doc/BRIEF.md
# Status-Polling Serial Flash Host

This block is a small SPI master that waits for a serial flash device to finish an internal program or erase operation. When the user logic raises `start`, the host pulls chip select low and shifts out the status-read command. It then clocks in status bits until the device reports ready. The outcome is returned as a one-cycle `done` pulse, together with the last complete status byte and a flag that tells whether the wait ran out of time.

Two polling styles are chosen at build time. In full-byte polling the host keeps clocking whole status bytes until one of them has its ready bit set. In parked polling the host stops SCK, held low, right after the device has presented the ready bit. It then watches MISO, which continues to show that bit, until the bit turns to 1. Only then does it clock in one complete status byte. A cycle counter bounds the whole wait and, if it runs out, ends the transaction at once.

Top module: `sfpoll_host`

## Requirements
- R1: After reset `csN` is 1, `sck` is 0, `mosi` is 0, `done` is 0, `timedOut` is 0 and `statusByte` is 0.
- R2: A transaction holds `csN` low from the `start` edge until it ends. It runs in SPI mode 0: SCK idles low and MOSI changes only while SCK is low. The first eight SCK rising edges carry the command byte 0x57, most significant bit first.
- R3: Every SCK high phase lasts exactly `CLK_DIV` clock cycles, unless a timeout cuts it short.
- R4: Status bits are sampled on the SCK rising edges after the eighth one, most significant bit first, in groups of eight. At the end of each group `statusByte` takes bits 7..3 of the received byte, and bits 2..0 are driven as 0. Bit 7 = 1 means ready and 0 means busy.
- R5: With `PARK_MODE` = 0, the host clocks whole status bytes and stops after the first byte whose bit 7 is 1. The total number of SCK rising edges is therefore 8 + 8·k with k ≥ 1, and it is exactly 16 when the device is ready from the start.
- R6: With `PARK_MODE` = 1, after the eighth falling edge SCK stays low until MISO reads 1. The host then clocks exactly one status byte, for exactly 16 rising edges in total. If the device never becomes ready, only the 8 command edges occur.
- R7: On normal completion, the last SCK falling edge is followed after one half period by `csN` returning to 1. In that same cycle `done` pulses for one cycle, and `timedOut` is 0.
- R8: If no completion has occurred, then exactly `TIMEOUT_CYCLES` clock cycles after the `start` edge `done` pulses and `timedOut` becomes 1. In the same cycle `csN` goes to 1 and `sck` goes to 0.
- R9: A `start` raised while a transaction is in progress is ignored: there is no extra `done` pulse and the SCK sequence is unchanged.
- R10: A new transaction clears `timedOut` and `statusByte` to 0 at its `start` edge. After a timeout, `statusByte` holds the last complete byte received, or 0 if no byte was completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a polling transaction (sampled when idle) |
| done | output | 1 | One-cycle pulse when the transaction ends |
| timedOut | output | 1 | Set when the last transaction ended by timeout |
| statusByte | output | 8 | Last complete status byte, low three bits zero |
| sck | output | 1 | Serial clock to the flash |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The bench builds two copies of the host side by side, one in each polling mode. Both use `CLK_DIV` = 2 and `TIMEOUT_CYCLES` = 400, so a status byte takes 32 cycles and a timeout fits inside a short run. With these values the bench can sweep device busy times from zero up to several status bytes for each of several status patterns. It covers both the exact-16-edge and the multi-byte cases, hits the exact timeout cycle in both modes, and checks that parked mode never clocks past the command while the device stays busy.

// File: rtl/sfpoll_pkg.sv
package sfpoll_pkg;

  localparam logic [7:0] STATUS_OPCODE = 8'h57;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_RUN,
    PH_PARK,
    PH_LAST,
    PH_TAIL
  } sfpoll_phase_e;

  typedef struct packed {
    logic launch;
    logic rise;
    logic fall;
    logic release_;
    logic abort;
  } sfpoll_strobe_t;

endpackage

// File: rtl/sfpoll_datapath.sv
module sfpoll_datapath
  import sfpoll_pkg::*;
#(
  parameter int CLK_DIV        = 4,
  parameter int TIMEOUT_CYCLES = 1000000
) (
  input  logic           clk,
  input  logic           rstN,
  input  sfpoll_strobe_t stb,
  input  logic           active,
  input  logic           miso,
  output logic           tick,
  output logic           expired,
  output logic           sck,
  output logic           csN,
  output logic           mosi,
  output logic [3:0]     riseCnt,
  output logic           rxTop,
  output logic [7:0]     statusByte,
  output logic           done,
  output logic           timedOut
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam int HL_W  = $clog2(CLK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);

  logic [DIV_W-1:0] divCnt;
  logic [TMO_W-1:0] timer;
  logic [7:0]       opShift;
  logic [6:0]       rxShift;
  logic [HL_W-1:0]  highLen;
  logic             inStatus;
  logic             byteEnd;

  // half-period tick generator
  assign tick = active && (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || !active || stb.launch) begin
      divCnt <= '0;
    end else if (tick) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // transaction time bound
  assign expired = active && (timer == TMO_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || stb.launch) begin
      timer <= '0;
    end else if (active && !expired) begin
      timer <= timer + 1'b1;
    end
  end

  // pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sck <= 1'b0;
      csN <= 1'b1;
    end else begin
      if (stb.launch) begin
        csN <= 1'b0;
      end else if (stb.release_ || stb.abort) begin
        csN <= 1'b1;
      end
      if (stb.rise) begin
        sck <= 1'b1;
      end else if (stb.fall || stb.release_ || stb.abort || stb.launch) begin
        sck <= 1'b0;
      end
    end
  end

  // command shifter: next bit is presented on each falling edge
  always_ff @(posedge clk) begin
    if (!rstN || stb.release_ || stb.abort) begin
      opShift <= '0;
    end else if (stb.launch) begin
      opShift <= STATUS_OPCODE;
    end else if (stb.fall) begin
      opShift <= {opShift[6:0], 1'b0};
    end
  end

  assign mosi = opShift[7];

  // edge counter: 0..7 command, 8..15 status, wrapping within status
  assign inStatus = riseCnt[3];
  assign byteEnd  = stb.rise && (riseCnt == 4'd15);

  always_ff @(posedge clk) begin
    if (!rstN || stb.launch) begin
      riseCnt <= '0;
    end else if (stb.rise) begin
      riseCnt <= (riseCnt == 4'd15) ? 4'd8 : riseCnt + 4'd1;
    end
  end

  // status capture
  always_ff @(posedge clk) begin
    if (!rstN || stb.launch) begin
      rxShift <= '0;
    end else if (stb.rise && inStatus) begin
      rxShift <= {rxShift[5:0], miso};
    end
  end

  assign rxTop = rxShift[6];

  always_ff @(posedge clk) begin
    if (!rstN || stb.launch) begin
      statusByte <= '0;
    end else if (byteEnd) begin
      statusByte <= {rxShift[6:2], 3'b000};
    end
  end

  // completion flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      done     <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      done <= stb.release_ || stb.abort;
      if (stb.launch) begin
        timedOut <= 1'b0;
      end else if (stb.abort) begin
        timedOut <= 1'b1;
      end
    end
  end

  // high-phase length tracker for the clock-shape check
  always_ff @(posedge clk) begin
    if (!rstN || !sck) begin
      highLen <= '0;
    end else begin
      highLen <= highLen + 1'b1;
    end
  end

  AST_CS_IDLE_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck) else $error("sck high with chip select released"); // R2

  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi)) else $error("mosi moved while sck high"); // R2

  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    sck |-> (highLen < HL_W'(CLK_DIV))) else $error("sck high phase too long"); // R3

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (timer <= TMO_LAST)) else $error("timer passed its limit"); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done longer than one cycle"); // R7

  AST_DONE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && !sck)) else $error("done with bus still active"); // R7

endmodule

// File: rtl/sfpoll_control.sv
module sfpoll_control
  import sfpoll_pkg::*;
#(
  parameter int PARK_MODE = 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           tick,
  input  logic           expired,
  input  logic           sckLevel,
  input  logic           miso,
  input  logic [3:0]     riseCnt,
  input  logic           rxTop,
  output sfpoll_strobe_t stb,
  output logic           active
);

  localparam bit PARKED = (PARK_MODE != 0);

  sfpoll_phase_e phase, phaseNext;

  assign active = (phase != PH_IDLE);

  always_comb begin
    stb       = '0;
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          stb.launch = 1'b1;
          phaseNext  = PH_LEAD;
        end
      end
      PH_LEAD: begin
        if (tick) begin
          stb.rise  = 1'b1;
          phaseNext = PH_RUN;
        end
      end
      PH_RUN: begin
        if (tick) begin
          if (sckLevel) begin
            stb.fall = 1'b1;
            // R6: park right after the ready bit has been presented
            if (PARKED && (riseCnt == 4'd8)) begin
              phaseNext = PH_PARK;
            end
          end else begin
            stb.rise = 1'b1;
            // R5/R6: last bit of a status byte decides whether to stop
            if ((riseCnt == 4'd15) && (PARKED || rxTop)) begin
              phaseNext = PH_LAST;
            end
          end
        end
      end
      PH_PARK: begin
        if (tick && miso) begin
          stb.rise  = 1'b1;
          phaseNext = PH_RUN;
        end
      end
      PH_LAST: begin
        if (tick) begin
          stb.fall  = 1'b1;
          phaseNext = PH_TAIL;
        end
      end
      PH_TAIL: begin
        if (tick) begin
          stb.release_ = 1'b1;
          phaseNext    = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
    if (expired) begin
      stb       = '0;
      stb.abort = 1'b1;
      phaseNext = PH_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phaseNext;
    end
  end

  AST_PARK_SCK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PARK) |-> !sckLevel) else $error("sck not parked low"); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (active && start && !expired) |=> (phase != PH_LEAD || $past(phase) == PH_LEAD))
    else $error("restart while busy"); // R9

endmodule

// File: rtl/sfpoll_host.sv
module sfpoll_host
  import sfpoll_pkg::*;
#(
  parameter int CLK_DIV        = 4,
  parameter int TIMEOUT_CYCLES = 1000000,
  parameter int PARK_MODE      = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output logic       done,
  output logic       timedOut,
  output logic [7:0] statusByte,
  output logic       sck,
  output logic       csN,
  output logic       mosi,
  input  logic       miso
);

  sfpoll_strobe_t stb;
  logic           active;
  logic           tick;
  logic           expired;
  logic [3:0]     riseCnt;
  logic           rxTop;

  sfpoll_control #(
    .PARK_MODE(PARK_MODE)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .tick     (tick),
    .expired  (expired),
    .sckLevel (sck),
    .miso     (miso),
    .riseCnt  (riseCnt),
    .rxTop    (rxTop),
    .stb      (stb),
    .active   (active)
  );

  sfpoll_datapath #(
    .CLK_DIV        (CLK_DIV),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .active     (active),
    .miso       (miso),
    .tick       (tick),
    .expired    (expired),
    .sck        (sck),
    .csN        (csN),
    .mosi       (mosi),
    .riseCnt    (riseCnt),
    .rxTop      (rxTop),
    .statusByte (statusByte),
    .done       (done),
    .timedOut   (timedOut)
  );

endmodule

// File: tb/sfpoll_host_bench.sv
module sfpoll_flash_stub (
  input  logic       sck,
  input  logic       csN,
  input  logic       mosi,
  input  logic       readyNow,
  input  logic [7:0] pattern,
  output logic       miso,
  output logic [7:0] opcode,
  output int         rises
);
  int   falls = 0;
  logic prevCs = 1'b1;
  logic prevSck = 1'b0;
  int   pos;

  initial begin
    rises  = 0;
    opcode = '0;
  end

  always @(csN, sck) begin
    if (prevCs && !csN) begin
      falls  = 0;
      rises  = 0;
      opcode = '0;
    end else if (!csN && !prevSck && sck) begin
      if (rises < 8) opcode = {opcode[6:0], mosi};
      rises = rises + 1;
    end else if (!csN && prevSck && !sck) begin
      falls = falls + 1;
    end
    prevCs  = csN;
    prevSck = sck;
  end

  assign pos  = 7 - ((falls - 8) % 8);
  assign miso = (falls < 8) ? 1'b0 : ((pos == 7) ? readyNow : pattern[pos[2:0]]);
endmodule

module sfpoll_host_bench;
  localparam int DIV = 2;
  localparam int TMO = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  longint cyc = 0;
  longint readyAt = 64'h7fff_ffff_ffff;
  logic readyNow;
  logic [7:0] pattern = 8'h00;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign readyNow = (cyc >= readyAt);

  logic sckP, csNP, mosiP, misoP, doneP, toP;
  logic [7:0] statP, opP;
  int risesP;
  logic sckF, csNF, mosiF, misoF, doneF, toF;
  logic [7:0] statF, opF;
  int risesF;

  sfpoll_host #(.CLK_DIV(DIV), .TIMEOUT_CYCLES(TMO), .PARK_MODE(1)) u_sfpoll_host (
    .clk(clk), .rstN(rstN), .start(start), .done(doneP), .timedOut(toP),
    .statusByte(statP), .sck(sckP), .csN(csNP), .mosi(mosiP), .miso(misoP));
  sfpoll_host #(.CLK_DIV(DIV), .TIMEOUT_CYCLES(TMO), .PARK_MODE(0)) u_sfpoll_host_full (
    .clk(clk), .rstN(rstN), .start(start), .done(doneF), .timedOut(toF),
    .statusByte(statF), .sck(sckF), .csN(csNF), .mosi(mosiF), .miso(misoF));

  sfpoll_flash_stub u_stubP (.sck(sckP), .csN(csNP), .mosi(mosiP), .readyNow(readyNow),
    .pattern(pattern), .miso(misoP), .opcode(opP), .rises(risesP));
  sfpoll_flash_stub u_stubF (.sck(sckF), .csN(csNF), .mosi(mosiF), .readyNow(readyNow),
    .pattern(pattern), .miso(misoF), .opcode(opF), .rises(risesF));

  // done recording and high-phase measurement, sampled mid-cycle
  int doneCntP = 0, doneCntF = 0;
  longint doneCycP, doneCycF;
  logic toAtP, toAtF, csAtP, csAtF, sckAtP, sckAtF;
  logic [7:0] statAtP, statAtF;
  int runP = 0, runF = 0, badRunP = 0, badRunF = 0;

  always @(negedge clk) begin
    if (doneP) begin
      doneCntP++; doneCycP = cyc; toAtP = toP; statAtP = statP; csAtP = csNP; sckAtP = sckP;
    end
    if (doneF) begin
      doneCntF++; doneCycF = cyc; toAtF = toF; statAtF = statF; csAtF = csNF; sckAtF = sckF;
    end
    if (sckP) runP++;
    else begin
      if (runP != 0 && !csNP && runP != DIV) badRunP++;
      runP = 0;
    end
    if (sckF) runF++;
    else begin
      if (runF != 0 && !csNF && runF != DIV) badRunF++;
      runF = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    end
  endtask

  task automatic runTrial(input int d, input logic [7:0] pat, input bit neverReady,
                          input bit poke, input bit afterTimeout);
    int dP0, dF0, bP0, bF0;
    longint startCyc;
    logic [7:0] expReady;
    pattern = pat;
    @(negedge clk);
    readyAt = neverReady ? 64'h7fff_ffff_ffff : (cyc + 1 + d);
    dP0 = doneCntP; dF0 = doneCntF; bP0 = badRunP; bF0 = badRunF;
    start = 1'b1;
    @(posedge clk);
    #1 startCyc = cyc;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(csNP == 1'b0 && csNF == 1'b0, "R2", "chip select low during run", {csNP, csNF}, 0);
    if (afterTimeout) begin
      chk(toP == 1'b0 && toF == 1'b0, "R10", "timedOut cleared at start", {toP, toF}, 0);
      chk(statF == 8'h00, "R10", "statusByte cleared at start", statF, 0);
    end
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      if (doneCntP != dP0 && doneCntF != dF0) break;
      @(negedge clk);
    end
    repeat (12) @(negedge clk);

    expReady = {1'b1, pat[6:3], 3'b000};
    chk(doneCntP - dP0 == 1, poke ? "R9" : "R7", "parked done pulses", doneCntP - dP0, 1);
    chk(doneCntF - dF0 == 1, poke ? "R9" : "R7", "full done pulses", doneCntF - dF0, 1);
    chk(opP == 8'h57, "R2", "parked opcode", opP, 8'h57);
    chk(opF == 8'h57, "R2", "full opcode", opF, 8'h57);
    chk(badRunP == bP0 && badRunF == bF0, "R3", "sck high phase length",
        (badRunP - bP0) + (badRunF - bF0), 0);
    chk(csAtP && !sckAtP && csAtF && !sckAtF, neverReady ? "R8" : "R7",
        "bus idle with done", {csAtP, sckAtP, csAtF, sckAtF}, 4'b1010);
    if (neverReady) begin
      chk(toAtP == 1'b1, "R8", "parked timedOut", toAtP, 1);
      chk(toAtF == 1'b1, "R8", "full timedOut", toAtF, 1);
      chk(doneCycP - startCyc == TMO, "R8", "parked timeout cycle", doneCycP - startCyc, TMO);
      chk(doneCycF - startCyc == TMO, "R8", "full timeout cycle", doneCycF - startCyc, TMO);
      chk(statAtP == 8'h00, "R10", "parked status after timeout", statAtP, 0);
      chk(statAtF == {1'b0, pat[6:3], 3'b000}, "R4", "full status after timeout",
          statAtF, {1'b0, pat[6:3], 3'b000});
      chk(risesP == 8, "R6", "parked edges while busy", risesP, 8);
    end else begin
      chk(toAtP == 1'b0, "R7", "parked timedOut", toAtP, 0);
      chk(toAtF == 1'b0, "R7", "full timedOut", toAtF, 0);
      chk(statAtP == expReady, "R4", "parked status", statAtP, expReady);
      chk(statAtF == expReady, "R4", "full status", statAtF, expReady);
      chk(risesP == 16, "R6", "parked edge count", risesP, 16);
      chk(risesF % 8 == 0 && risesF >= 16, "R5", "full edge count shape", risesF, 16);
      if (d == 0) chk(risesF == 16, "R5", "full edge count ready at once", risesF, 16);
      if (d >= 150) chk(risesF > 16, "R5", "full edge count busy device", risesF, 17);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    int delays[6] = '{0, 6, 40, 90, 150, 230};
    logic [7:0] pats[4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    repeat (4) @(negedge clk);
    chk(csNP && csNF && !sckP && !sckF && !mosiP && !mosiF, "R1", "pins after reset",
        {csNP, sckP, mosiP}, 3'b100);
    chk(!doneP && !toP && statP == 0 && !doneF && !toF && statF == 0, "R1",
        "flags after reset", {doneP, toP, statP}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    for (int di = 0; di < 6; di++) begin
      for (int pi = 0; pi < 4; pi++) begin
        runTrial(delays[di], pats[pi], 1'b0, (di == 2 && pi == 1), 1'b0);
      end
    end
    runTrial(0, 8'hC8, 1'b1, 1'b0, 1'b0);
    runTrial(10, 8'h3C, 1'b0, 1'b0, 1'b1);
    runTrial(0, 8'h77, 1'b1, 1'b1, 1'b0);
    runTrial(0, 8'h81, 1'b0, 1'b0, 1'b1);
    summary();
    $finish;
  end

endmodule